// File: doc/BRIEF.md
# AHB Bus Statistics Counter Unit

This block watches an AHB bus without driving it and keeps running performance figures on what it sees: how each completed transfer ended, how many cycles the bus stalled, how long masters waited for a grant, how many real accesses and locked accesses went by, and two per master/slave figures. The first per-pair figure is how long locked activity lasted. The second is how long a master stayed away from the bus after a SPLIT response before it issued its next address phase.

An external enable input gates counting. A monitoring system can drive it from its own trigger logic so that figures are collected only inside a window of interest. Every counter saturates at all ones and does not wrap. One clear pulse zeroes every counter at once. Software-facing logic reads the figures through a plain combinational index/data read port. The per-pair tables are sized by the master count and the slave count.

Top module: `ahb_stat_unit`

## Requirements
- R1: A data phase (the cycle after an address phase accepted with HREADY high and HTRANS NONSEQ or SEQ) is counted once, in the cycle where HREADY is high, into the counter for its HRESP code: OKAY=2'b00 (read index 0), ERROR=2'b01 (index 1), RETRY=2'b10 (index 2), SPLIT=2'b11 (index 3). The low-HREADY first cycle of a two-cycle response adds nothing.
- R2: Each enabled cycle with HREADY low adds one to the wait-state counter (index 4).
- R3: Each enabled cycle adds to the grant-delay counter (index 5) the number of masters whose request bit is high while their grant bit is low.
- R4: Each address phase accepted with HREADY high and HTRANS NONSEQ (2'b10) or SEQ (2'b11) adds one to the access counter (index 6). IDLE (2'b00) and BUSY (2'b01) never count.
- R5: An access counted by R4 while HMASTLOCK is high also adds one to the locked-access counter (index 7).
- R6: Each enabled cycle with HMASTLOCK high, HTRANS not IDLE and at least one select bit high adds one to the locked-length entry of the pair (HMASTER, lowest set select bit). That entry is read at index 8 + master*NS + slave.
- R7: After a SPLIT response completes for master m to slave s, every later enabled cycle adds one to the split-recovery entry (m, s) until master m's next accepted address phase. That cycle itself is not counted. The entry is read at index 8 + NM*NS + m*NS + s.
- R8: While the enable input is low, no counter changes. Split tracking still follows the bus.
- R9: A clear pulse zeroes every counter in the next cycle and takes priority over any increment in that cycle.
- R10: Every counter saturates at all ones and never wraps.
- R11: The read port returns the addressed counter combinationally. Any index at or above 8 + 2*NM*NS reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_en | input | 1 | Counting enable from external trigger logic |
| clr | input | 1 | Synchronous clear of all counters |
| hbusreq | input | NM | Per-master bus request |
| hgrant | input | NM | Per-master grant |
| htrans | input | 2 | Transfer type |
| hmastlock | input | 1 | Locked transfer indicator |
| hmaster | input | $clog2(NM) | Current address-phase master |
| hsel | input | NS | Slave selects |
| hready | input | 1 | Transfer done / bus ready |
| hresp | input | 2 | Transfer response |
| rd_idx | input | IW | Counter read index |
| rd_data | output | CW | Addressed counter value |

## Verification
The hardest case to reach is split recovery. The bench has to produce a full two-cycle SPLIT completion. It then keeps the split master off the bus while other masters and idle cycles go by, and checks that the entry stops exactly at the split master's next accepted NONSEQ, not at a cycle where HMASTER merely names that master. The stimulus builds this sequence cycle by cycle, and the bench model keeps per-master pending state written from the requirement. A separate long stall with every master requesting drives the wait and grant counters into saturation on a narrow-counter instance.

// File: rtl/ahb_stat_pkg.sv
package ahb_stat_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    typedef enum logic [1:0] {
        RS_OKAY  = 2'b00,
        RS_ERROR = 2'b01,
        RS_RETRY = 2'b10,
        RS_SPLIT = 2'b11
    } resp_e;

    // read-map slots of the scalar counters
    localparam int SLOT_OKAY   = 0;
    localparam int SLOT_ERROR  = 1;
    localparam int SLOT_RETRY  = 2;
    localparam int SLOT_SPLIT  = 3;
    localparam int SLOT_WAIT   = 4;
    localparam int SLOT_GRANT  = 5;
    localparam int SLOT_ACCESS = 6;
    localparam int SLOT_LOCKED = 7;
    localparam int NUM_SCALAR  = 8;

endpackage

// File: rtl/ahb_stat_ctr.sv
module ahb_stat_ctr #(
    parameter int CW = 32,
    parameter int AW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [AW-1:0] inc,
    output logic [CW-1:0] cnt
);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW:0]   sum;

    always_comb begin
        sum = {1'b0, cnt_q} + (CW+1)'(inc);
        if (clr)
            cnt_d = '0;
        else if (sum[CW])
            cnt_d = '1;
        else
            cnt_d = sum[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt_q >= $past(cnt_q));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);

endmodule

// File: rtl/ahb_stat_pair_tbl.sv
module ahb_stat_pair_tbl #(
    parameter int NM = 4,
    parameter int NS = 4,
    parameter int CW = 32,
    localparam int NP = NM * NS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic [NP-1:0]          hit,
    output logic [NP-1:0][CW-1:0]  cnt
);

    for (genvar p = 0; p < NP; p++) begin : g_cell
        ahb_stat_ctr #(.CW(CW), .AW(1)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (hit[p]),
            .cnt   (cnt[p])
        );
    end

endmodule

// File: rtl/ahb_stat_events.sv
module ahb_stat_events
    import ahb_stat_pkg::*;
#(
    parameter int NM = 4,
    parameter int NS = 4,
    localparam int MW = (NM > 1) ? $clog2(NM) : 1,
    localparam int SW = (NS > 1) ? $clog2(NS) : 1,
    localparam int GW = $clog2(NM + 1),
    localparam int NP = NM * NS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_en,
    input  logic [NM-1:0] hbusreq,
    input  logic [NM-1:0] hgrant,
    input  logic [1:0]    htrans,
    input  logic          hmastlock,
    input  logic [MW-1:0] hmaster,
    input  logic [NS-1:0] hsel,
    input  logic          hready,
    input  logic [1:0]    hresp,
    output logic [3:0]    inc_resp,
    output logic          inc_wait,
    output logic [GW-1:0] inc_grant,
    output logic          inc_acc,
    output logic          inc_lock,
    output logic [NP-1:0] lock_hit,
    output logic [NP-1:0] split_hit
);

    typedef struct packed {
        logic                   dval;
        logic [MW-1:0]          dmst;
        logic [SW-1:0]          dslv;
        logic                   dslv_ok;
        logic [NM-1:0]          pend;
        logic [NM-1:0][SW-1:0]  pslv;
    } trk_t;

    trk_t trk_d, trk_q;

    logic          addr_ok;
    logic [SW-1:0] sel_idx;
    logic          sel_ok;
    logic          lock_cyc;
    logic          done_cyc;

    always_comb begin
        sel_idx = '0;
        sel_ok  = 1'b0;
        for (int s = NS - 1; s >= 0; s--) begin
            if (hsel[s]) begin
                sel_idx = SW'(s);
                sel_ok  = 1'b1;
            end
        end
    end

    always_comb begin
        addr_ok  = hready && htrans[1];
        done_cyc = trk_q.dval && hready;
        lock_cyc = hmastlock && (htrans != TR_IDLE) && sel_ok;

        // counter increments
        inc_resp = '0;
        if (trig_en && done_cyc)
            inc_resp[hresp] = 1'b1;
        inc_wait  = trig_en && !hready;
        inc_grant = '0;
        if (trig_en)
            inc_grant = GW'($countones(hbusreq & ~hgrant));
        inc_acc   = trig_en && addr_ok;
        inc_lock  = trig_en && addr_ok && hmastlock;

        lock_hit  = '0;
        split_hit = '0;
        for (int m = 0; m < NM; m++) begin
            for (int s = 0; s < NS; s++) begin
                lock_hit[m*NS+s] = trig_en && lock_cyc &&
                                   (hmaster == MW'(m)) && (sel_idx == SW'(s));
                split_hit[m*NS+s] = trig_en && trk_q.pend[m] &&
                                    (trk_q.pslv[m] == SW'(s)) &&
                                    !(addr_ok && hmaster == MW'(m));
            end
        end

        // tracking state, independent of trig_en
        trk_d = trk_q;
        for (int m = 0; m < NM; m++) begin
            if (trk_q.pend[m] && addr_ok && hmaster == MW'(m))
                trk_d.pend[m] = 1'b0;
        end
        if (done_cyc && hresp == RS_SPLIT && trk_q.dslv_ok) begin
            trk_d.pend[trk_q.dmst] = 1'b1;
            trk_d.pslv[trk_q.dmst] = trk_q.dslv;
        end
        if (hready) begin
            trk_d.dval    = addr_ok;
            trk_d.dmst    = hmaster;
            trk_d.dslv    = sel_idx;
            trk_d.dslv_ok = sel_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assert_one_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inc_resp));

    assert_no_resp_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |-> inc_resp == '0);

    assert_idle_no_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !htrans[1] |-> !inc_acc);

    assert_lock_is_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inc_lock |-> inc_acc);

    assert_lock_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lock_hit));

    assert_split_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_cyc && hresp == RS_SPLIT && trk_q.dslv_ok) |=> trk_q.pend[$past(trk_q.dmst)]);

    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_en |-> (inc_resp == '0 && !inc_wait && inc_grant == '0 &&
                      lock_hit == '0 && split_hit == '0));

endmodule

// File: rtl/ahb_stat_unit.sv
module ahb_stat_unit
    import ahb_stat_pkg::*;
#(
    parameter int NM = 4,
    parameter int NS = 4,
    parameter int CW = 32,
    parameter int IW = 8,
    localparam int MW = (NM > 1) ? $clog2(NM) : 1,
    localparam int GW = $clog2(NM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_en,
    input  logic          clr,
    input  logic [NM-1:0] hbusreq,
    input  logic [NM-1:0] hgrant,
    input  logic [1:0]    htrans,
    input  logic          hmastlock,
    input  logic [MW-1:0] hmaster,
    input  logic [NS-1:0] hsel,
    input  logic          hready,
    input  logic [1:0]    hresp,
    input  logic [IW-1:0] rd_idx,
    output logic [CW-1:0] rd_data
);

    localparam int NP        = NM * NS;
    localparam int LOCK_BASE = NUM_SCALAR;
    localparam int SPL_BASE  = NUM_SCALAR + NP;

    logic [3:0]    inc_resp;
    logic          inc_wait;
    logic [GW-1:0] inc_grant;
    logic          inc_acc;
    logic          inc_lock;
    logic [NP-1:0] lock_hit;
    logic [NP-1:0] split_hit;

    logic [NUM_SCALAR-1:0][GW-1:0] scal_inc;
    logic [NUM_SCALAR-1:0][CW-1:0] scal_cnt;
    logic [NP-1:0][CW-1:0]         lock_cnt;
    logic [NP-1:0][CW-1:0]         split_cnt;

    ahb_stat_events #(.NM(NM), .NS(NS)) u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_en   (trig_en),
        .hbusreq   (hbusreq),
        .hgrant    (hgrant),
        .htrans    (htrans),
        .hmastlock (hmastlock),
        .hmaster   (hmaster),
        .hsel      (hsel),
        .hready    (hready),
        .hresp     (hresp),
        .inc_resp  (inc_resp),
        .inc_wait  (inc_wait),
        .inc_grant (inc_grant),
        .inc_acc   (inc_acc),
        .inc_lock  (inc_lock),
        .lock_hit  (lock_hit),
        .split_hit (split_hit)
    );

    always_comb begin
        scal_inc              = '0;
        scal_inc[SLOT_OKAY]   = GW'(inc_resp[RS_OKAY]);
        scal_inc[SLOT_ERROR]  = GW'(inc_resp[RS_ERROR]);
        scal_inc[SLOT_RETRY]  = GW'(inc_resp[RS_RETRY]);
        scal_inc[SLOT_SPLIT]  = GW'(inc_resp[RS_SPLIT]);
        scal_inc[SLOT_WAIT]   = GW'(inc_wait);
        scal_inc[SLOT_GRANT]  = inc_grant;
        scal_inc[SLOT_ACCESS] = GW'(inc_acc);
        scal_inc[SLOT_LOCKED] = GW'(inc_lock);
    end

    for (genvar k = 0; k < NUM_SCALAR; k++) begin : g_scalar
        ahb_stat_ctr #(.CW(CW), .AW(GW)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (scal_inc[k]),
            .cnt   (scal_cnt[k])
        );
    end

    ahb_stat_pair_tbl #(.NM(NM), .NS(NS), .CW(CW)) u_lock_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .hit   (lock_hit),
        .cnt   (lock_cnt)
    );

    ahb_stat_pair_tbl #(.NM(NM), .NS(NS), .CW(CW)) u_split_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .hit   (split_hit),
        .cnt   (split_cnt)
    );

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_SCALAR; k++)
            if (rd_idx == IW'(k)) rd_data = scal_cnt[k];
        for (int p = 0; p < NP; p++) begin
            if (rd_idx == IW'(LOCK_BASE + p)) rd_data = lock_cnt[p];
            if (rd_idx == IW'(SPL_BASE + p))  rd_data = split_cnt[p];
        end
    end

    assert_wait_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en && !hready && !clr && scal_cnt[SLOT_WAIT] != '1) |=>
        scal_cnt[SLOT_WAIT] == $past(scal_cnt[SLOT_WAIT]) + 1'b1);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_en && !clr) |=> ($stable(scal_cnt) && $stable(lock_cnt) && $stable(split_cnt)));

endmodule

// File: tb/ahb_stat_unit_tb.sv
module ahb_stat_unit_tb;

    localparam int NM  = 4;
    localparam int NS  = 4;
    localparam int CW  = 8;
    localparam int IW  = 8;
    localparam int NP  = NM * NS;
    localparam int NR  = 8 + 2 * NP;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_en = 1'b0;
    logic          clr = 1'b0;
    logic [NM-1:0] hbusreq = '0;
    logic [NM-1:0] hgrant = '0;
    logic [1:0]    htrans = 2'b00;
    logic          hmastlock = 1'b0;
    logic [1:0]    hmaster = '0;
    logic [NS-1:0] hsel = '0;
    logic          hready = 1'b1;
    logic [1:0]    hresp = 2'b00;
    logic [IW-1:0] rd_idx = '0;
    logic [CW-1:0] rd_data;

    always #10 clk = ~clk;

    ahb_stat_unit #(.NM(NM), .NS(NS), .CW(CW), .IW(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .clr(clr),
        .hbusreq(hbusreq), .hgrant(hgrant), .htrans(htrans),
        .hmastlock(hmastlock), .hmaster(hmaster), .hsel(hsel),
        .hready(hready), .hresp(hresp), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    typedef struct { int idx; int exp; string tag; } item_t;
    item_t sb_q[$];

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // requirement-level model
    int  exp_cnt [NR];
    bit  m_dval;
    int  m_dmst, m_dslv;
    bit  m_dslv_ok;
    bit  m_pend [NM];
    int  m_pslv [NM];

    function automatic string req_of(int idx);
        if (idx < 4)       return "R1";
        if (idx == 4)      return "R2";
        if (idx == 5)      return "R3";
        if (idx == 6)      return "R4";
        if (idx == 7)      return "R5";
        if (idx < 8 + NP)  return "R6";
        if (idx < NR)      return "R7";
        return "R11";
    endfunction

    function automatic int low_sel(logic [NS-1:0] s);
        for (int k = 0; k < NS; k++) if (s[k]) return k;
        return -1;
    endfunction

    function automatic void bump(int idx, int amt);
        exp_cnt[idx] = (exp_cnt[idx] + amt > MAXV) ? MAXV : exp_cnt[idx] + amt;
    endfunction

    // one bus cycle: drive at negedge, update the model for the next posedge
    task automatic step(input logic [NM-1:0] br, input logic [NM-1:0] gn,
                        input logic [1:0] tr, input logic lk, input int mst,
                        input logic [NS-1:0] sl, input logic rdy, input logic [1:0] rs);
        bit acc;
        int si;
        @(negedge clk);
        hbusreq = br; hgrant = gn; htrans = tr; hmastlock = lk;
        hmaster = 2'(mst); hsel = sl; hready = rdy; hresp = rs;
        acc = rdy && tr[1];
        si  = low_sel(sl);
        if (clr) begin
            for (int k = 0; k < NR; k++) exp_cnt[k] = 0;
        end else if (trig_en) begin
            if (m_dval && rdy) bump(int'(rs), 1);
            if (!rdy) bump(4, 1);
            bump(5, $countones(br & ~gn));
            if (acc) bump(6, 1);
            if (acc && lk) bump(7, 1);
            if (lk && tr != 2'b00 && si >= 0) bump(8 + mst * NS + si, 1);
            for (int m = 0; m < NM; m++)
                if (m_pend[m] && !(acc && mst == m)) bump(8 + NP + m * NS + m_pslv[m], 1);
        end
        for (int m = 0; m < NM; m++)
            if (m_pend[m] && acc && mst == m) m_pend[m] = 0;
        if (m_dval && rdy && rs == 2'b11 && m_dslv_ok) begin
            m_pend[m_dmst] = 1;
            m_pslv[m_dmst] = m_dslv;
        end
        if (rdy) begin
            m_dval = acc; m_dmst = mst; m_dslv = (si < 0) ? 0 : si; m_dslv_ok = (si >= 0);
        end
        @(posedge clk);
    endtask

    task automatic idle_cycle();
        step('0, '0, 2'b00, 1'b0, 0, '0, 1'b1, 2'b00);
    endtask

    // driver side of the scoreboard: queue every expected counter value
    task automatic check_all(input string tag);
        @(negedge clk);
        trig_en = 1'b0;
        for (int k = 0; k < NR; k++) begin
            item_t it;
            it.idx = k; it.exp = exp_cnt[k]; it.tag = tag;
            sb_q.push_back(it);
        end
        begin
            item_t it;
            it.idx = 200; it.exp = 0; it.tag = tag;
            sb_q.push_back(it);
        end
        wait (sb_q.size() == 0);
        #2;
    endtask

    // monitor side: read each queued index and compare
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            rd_idx = IW'(it.idx);
            #1;
            total++;
            if (int'(rd_data) != it.exp) begin
                bad++;
                $display("FAIL %s %s idx=%0d got=%0d exp=%0d",
                         it.tag, req_of(it.idx), it.idx, rd_data, it.exp);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, got=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NR; k++) exp_cnt[k] = 0;
        for (int m = 0; m < NM; m++) begin m_pend[m] = 0; m_pslv[m] = 0; end
        m_dval = 0; m_dmst = 0; m_dslv = 0; m_dslv_ok = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // reset state: all counters zero, out-of-range index R11
        check_all("reset");

        // main traffic with counting enabled
        @(negedge clk); trig_en = 1'b1;
        step(4'b0010, 4'b0000, 2'b10, 0, 1, 4'b0100, 1, 2'b00); // NONSEQ m1->s2, R3 +1
        step(4'b0010, 4'b0010, 2'b11, 0, 1, 4'b0100, 1, 2'b00); // SEQ, OKAY R1
        step('0, '0, 2'b00, 0, 1, 4'b0100, 1, 2'b00);           // OKAY, IDLE not R4
        step('0, '0, 2'b01, 0, 1, 4'b0100, 0, 2'b00);           // BUSY with stall R2
        step('0, '0, 2'b10, 0, 0, 4'b0001, 1, 2'b00);           // m0->s0
        step('0, '0, 2'b00, 0, 0, '0, 0, 2'b01);                // ERROR first cycle
        step('0, '0, 2'b00, 0, 0, '0, 1, 2'b01);                // ERROR counted once
        repeat (3) step(4'b1011, 4'b0000, 2'b00, 0, 0, '0, 1, 2'b00); // R3 +3 each
        step(4'b1011, 4'b0001, 2'b00, 0, 0, '0, 1, 2'b00);      // R3 +2
        // locked sequence m2->s1, R5 and R6
        step('0, '0, 2'b10, 1, 2, 4'b0010, 1, 2'b00);
        step('0, '0, 2'b11, 1, 2, 4'b0010, 1, 2'b00);
        step('0, '0, 2'b11, 1, 2, 4'b0010, 0, 2'b00);
        step('0, '0, 2'b11, 1, 2, 4'b0010, 1, 2'b00);
        step('0, '0, 2'b00, 0, 2, 4'b0010, 1, 2'b00);
        // SPLIT for m3->s3, then recovery R7
        step('0, '0, 2'b10, 0, 3, 4'b1000, 1, 2'b00);
        step('0, '0, 2'b00, 0, 3, '0, 0, 2'b11);
        step('0, '0, 2'b00, 0, 3, '0, 1, 2'b11);
        step('0, '0, 2'b10, 0, 1, 4'b0001, 1, 2'b00);           // other master
        step('0, '0, 2'b00, 0, 1, '0, 1, 2'b00);
        step('0, '0, 2'b00, 0, 3, '0, 1, 2'b00);                // m3 named but IDLE
        step('0, '0, 2'b10, 0, 3, 4'b1000, 1, 2'b00);           // m3 returns: stops
        step('0, '0, 2'b00, 0, 3, '0, 1, 2'b00);
        // RETRY m0->s1
        step('0, '0, 2'b10, 0, 0, 4'b0010, 1, 2'b00);
        step('0, '0, 2'b00, 0, 0, '0, 0, 2'b10);
        step('0, '0, 2'b00, 0, 0, '0, 1, 2'b10);
        idle_cycle();
        check_all("traffic");

        // disabled: activity must leave every counter unchanged R8
        @(negedge clk); trig_en = 1'b0;
        step(4'b1111, '0, 2'b10, 1, 2, 4'b0010, 1, 2'b00);
        step(4'b1111, '0, 2'b11, 1, 2, 4'b0010, 0, 2'b00);
        step('0, '0, 2'b00, 0, 2, '0, 1, 2'b01);
        idle_cycle();
        check_all("R8 gated");

        // clear during an incrementing cycle R9
        @(negedge clk); trig_en = 1'b1; clr = 1'b1;
        step(4'b1111, '0, 2'b10, 1, 1, 4'b0001, 0, 2'b00);
        @(negedge clk); clr = 1'b0; trig_en = 1'b0;
        idle_cycle();
        check_all("R9 clear");

        // saturation R10
        @(negedge clk); trig_en = 1'b1;
        for (int n = 0; n < 300; n++)
            step(4'b1111, '0, 2'b00, 0, 0, '0, 0, 2'b00);
        idle_cycle();
        check_all("R10 saturate");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule